// File: doc/BRIEF.md
# Pipelined Control Decoder with Per-Stage Control Fields

This block sits at the decode stage of a five-stage, in-order RISC pipeline. It takes each fetched 32-bit fixed-format instruction, decodes it once into a control bundle, and moves that bundle down the pipeline registers next to the data it governs. The execute stage reads its operand and ALU selections one cycle after decode. The memory stage reads its load, store and branch flags two cycles after decode. The writeback stage reads its register-write controls three cycles after decode. The block also extracts the source and destination register numbers and the extended immediate, and presents them with the execute-stage fields.

Every instruction that writes the register file does so in the fifth stage. A register-register operation passes through the memory stage as a no-operation, so it writes the register file in the same stage as a load, and a single write port is enough. The hazard logic around the block can use two inputs. One, a bubble request, squashes the instruction being decoded. The other, a stall, freezes the fetch/decode register and sends an empty slot into execute. An opcode or function code that the block does not know produces an all-zero bundle and raises an illegal-instruction flag.

Top module: `dsc_ctl_pipe`

## Requirements
- R1: The instruction fields are taken from these bit positions: opcode [31:26], first source [25:21], second source [20:16], register-register destination [15:11], function [5:0]. `ex_rs1` and `ex_rs2` always carry the two source fields. `ex_imm` carries one of three values, chosen by `ex_ext_sel`: [15:0] sign-extended (0), [15:0] zero-extended (1), or [25:0] zero-extended (2).
- R2: The execute group comes from the ID/EX register, so it appears after the second rising edge following the cycle in which the instruction is presented with `in_valid` high. These encodings apply. Opcodes: 0x00 register-register, 0x23 load, 0x2B store, 0x04 branch-equal, 0x05 branch-not-equal, 0x08 add-immediate, 0x0A set-less-than-immediate, 0x0C and-immediate (zero-extended), 0x0D or-immediate (zero-extended), 0x02 jump, 0x03 jump-and-link. Functions: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x26 xor, 0x2A set-less-than. `ex_alu_op` values: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 set-less-than. `ex_alu_src` is 1 when the second operand is the immediate. `ex_dst_sel` values: 0 rd field, 1 rt field, 2 link register.
- R3: The memory group (`mem_rd`, `mem_wr`, `mem_branch`, `mem_br_ne`, `mem_jump`) of an instruction appears one cycle after its execute group. A load sets only `mem_rd`. A store sets only `mem_wr`. Branches set `mem_branch`, and branch-not-equal also sets `mem_br_ne`. Both jumps set `mem_jump`. `mem_rd` and `mem_wr` are never high together.
- R4: The writeback group (`wb_mem_to_reg`, `wb_reg_wr`, `wb_dest`) appears two cycles after the execute group. This is the same fixed stage for register-register operations and for loads, so the two kinds of instruction issued back to back write in consecutive cycles, never in the same one.
- R5: The destination register is resolved as follows: the rd field for register-register operations, the rt field for loads and immediate operations, register 31 for jump-and-link. If the resolved destination is register 0, the register write is suppressed. `ex_dest` and `wb_dest` read 0 whenever the instruction does not write a register.
- R6: For an unknown opcode, or an unknown function under opcode 0x00, every control field and `ex_dest` read zero. `ex_illegal` reads 1. `ex_imm` takes the sign-extended form, and no memory or register write follows.
- R7: If `bubble_req` is high at an edge, the ID/EX register loads all zeros, and the instruction being decoded is dropped. The fetch/decode register still captures the input word.
- R8: If `stall` is high at an edge, the fetch/decode register keeps its contents and the ID/EX register loads all zeros. The held instruction is decoded at the first edge without a stall. A word presented during a stall is not captured.
- R9: A decode slot holding a word that was presented with `in_valid` low produces an all-zero ID/EX entry.
- R10: While `rst` is high at an edge, every output reads zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_instr | input | 32 | Fetched instruction word |
| in_valid | input | 1 | `in_instr` holds a real instruction |
| bubble_req | input | 1 | Squash the decoding instruction |
| stall | input | 1 | Hold fetch/decode and insert an empty slot |
| ex_ext_sel | output | 2 | Immediate extension select |
| ex_alu_src | output | 1 | Second ALU operand is the immediate |
| ex_alu_op | output | 3 | ALU operation |
| ex_dst_sel | output | 2 | Destination source select |
| ex_rs1 | output | 5 | First source register |
| ex_rs2 | output | 5 | Second source register |
| ex_dest | output | 5 | Resolved destination register |
| ex_imm | output | 32 | Extended immediate |
| ex_illegal | output | 1 | Unknown instruction in execute |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_branch | output | 1 | Conditional branch |
| mem_br_ne | output | 1 | Branch on not-equal |
| mem_jump | output | 1 | Unconditional jump |
| wb_mem_to_reg | output | 1 | Write back the memory data |
| wb_reg_wr | output | 1 | Register file write enable |
| wb_dest | output | 5 | Register written back |

## Verification
The assertions check these behaviours on every cycle:
- The memory and writeback groups only ever echo the stage before them one cycle late.
- A load and a store never share a memory stage.
- No write reaches register 0.
- A bubble, a stall or an empty slot always leaves execute entirely clear.
- A stalled fetch/decode register does not move.

Only the bench's scenarios can show the following:
- Each opcode and function maps to the correct ALU operation, extension and destination.
- Each group arrives at its exact cycle, including a load and a register-register operation issued back to back that write in consecutive cycles.
- After a stall, the held instruction, and not the word presented during the stall, is the one that finally decodes.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int XLEN    = 32;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;
    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RS1_LSB = OPC_LSB - RIDX_W;
    localparam int RS2_LSB = RS1_LSB - RIDX_W;
    localparam int RD_LSB  = RS2_LSB - RIDX_W;
    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(31);

    localparam logic [OPC_W-1:0] OP_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OP_JMP   = 6'h02;
    localparam logic [OPC_W-1:0] OP_JAL   = 6'h03;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_BNE   = 6'h05;
    localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OP_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OP_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OP_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR = 6'h26;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_SLT = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN   = 2'd0,
        EXT_ZERO   = 2'd1,
        EXT_TARGET = 2'd2
    } ext_sel_e;

    typedef enum logic [1:0] {
        DST_RD   = 2'd0,
        DST_RT   = 2'd1,
        DST_LINK = 2'd2
    } dst_sel_e;

    typedef struct packed {
        ext_sel_e ext_sel;
        logic     alu_src;
        alu_op_e  alu_op;
        dst_sel_e dst_sel;
    } ex_ctl_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic branch;
        logic br_ne;
        logic jump;
    } mem_ctl_t;

    typedef struct packed {
        logic mem_to_reg;
        logic reg_wr;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } ctl_bundle_t;

    typedef struct packed {
        ctl_bundle_t       ctl;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rs2;
        logic [RIDX_W-1:0] dest;
        logic [XLEN-1:0]   imm;
        logic              illegal;
    } idex_t;

    typedef struct packed {
        mem_ctl_t          mem;
        wb_ctl_t           wb;
        logic [RIDX_W-1:0] dest;
    } exmem_t;

    typedef struct packed {
        wb_ctl_t           wb;
        logic [RIDX_W-1:0] dest;
    } memwb_t;

    function automatic logic [OPC_W-1:0] f_opcode(input logic [XLEN-1:0] w);
        return w[OPC_LSB +: OPC_W];
    endfunction

    function automatic logic [FN_W-1:0] f_funct(input logic [XLEN-1:0] w);
        return w[0 +: FN_W];
    endfunction

    function automatic logic [RIDX_W-1:0] f_reg(input logic [XLEN-1:0] w, input int lsb);
        return w[lsb +: RIDX_W];
    endfunction

    function automatic logic [XLEN-1:0] f_extend(input logic [XLEN-1:0] w, input ext_sel_e sel);
        logic [XLEN-1:0] r;
        case (sel)
            EXT_ZERO:   r = {{(XLEN-IMM_W){1'b0}}, w[IMM_W-1:0]};
            EXT_TARGET: r = {{(XLEN-TGT_W){1'b0}}, w[TGT_W-1:0]};
            default:    r = {{(XLEN-IMM_W){w[IMM_W-1]}}, w[IMM_W-1:0]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsc_decoder.sv
module dsc_decoder
    import dsc_pkg::*;
(
    input  logic [XLEN-1:0] word,
    output idex_t           dec
);

    logic [OPC_W-1:0]  opc;
    logic [FN_W-1:0]   fn;
    logic              known;
    ctl_bundle_t       ctl;
    logic [RIDX_W-1:0] dest_raw;

    assign opc = f_opcode(word);
    assign fn  = f_funct(word);

    always_comb begin
        ctl   = '0;
        known = 1'b1;
        case (opc)
            OP_REG: begin
                ctl.ex.dst_sel = DST_RD;
                ctl.wb.reg_wr  = 1'b1;
                case (fn)
                    FN_ADD:  ctl.ex.alu_op = ALU_ADD;
                    FN_SUB:  ctl.ex.alu_op = ALU_SUB;
                    FN_AND:  ctl.ex.alu_op = ALU_AND;
                    FN_OR:   ctl.ex.alu_op = ALU_OR;
                    FN_XOR:  ctl.ex.alu_op = ALU_XOR;
                    FN_SLT:  ctl.ex.alu_op = ALU_SLT;
                    default: known = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctl.ex.alu_src    = 1'b1;
                ctl.ex.dst_sel    = DST_RT;
                ctl.mem.mem_rd    = 1'b1;
                ctl.wb.mem_to_reg = 1'b1;
                ctl.wb.reg_wr     = 1'b1;
            end
            OP_STORE: begin
                ctl.ex.alu_src = 1'b1;
                ctl.mem.mem_wr = 1'b1;
            end
            OP_BEQ: begin
                ctl.ex.alu_op  = ALU_SUB;
                ctl.mem.branch = 1'b1;
            end
            OP_BNE: begin
                ctl.ex.alu_op  = ALU_SUB;
                ctl.mem.branch = 1'b1;
                ctl.mem.br_ne  = 1'b1;
            end
            OP_ADDI: begin
                ctl.ex.alu_src = 1'b1;
                ctl.ex.dst_sel = DST_RT;
                ctl.wb.reg_wr  = 1'b1;
            end
            OP_SLTI: begin
                ctl.ex.alu_src = 1'b1;
                ctl.ex.alu_op  = ALU_SLT;
                ctl.ex.dst_sel = DST_RT;
                ctl.wb.reg_wr  = 1'b1;
            end
            OP_ANDI: begin
                ctl.ex.ext_sel = EXT_ZERO;
                ctl.ex.alu_src = 1'b1;
                ctl.ex.alu_op  = ALU_AND;
                ctl.ex.dst_sel = DST_RT;
                ctl.wb.reg_wr  = 1'b1;
            end
            OP_ORI: begin
                ctl.ex.ext_sel = EXT_ZERO;
                ctl.ex.alu_src = 1'b1;
                ctl.ex.alu_op  = ALU_OR;
                ctl.ex.dst_sel = DST_RT;
                ctl.wb.reg_wr  = 1'b1;
            end
            OP_JMP: begin
                ctl.ex.ext_sel = EXT_TARGET;
                ctl.mem.jump   = 1'b1;
            end
            OP_JAL: begin
                ctl.ex.ext_sel = EXT_TARGET;
                ctl.ex.dst_sel = DST_LINK;
                ctl.mem.jump   = 1'b1;
                ctl.wb.reg_wr  = 1'b1;
            end
            default: known = 1'b0;
        endcase
        if (!known) begin
            ctl = '0;
        end
    end

    always_comb begin
        case (ctl.ex.dst_sel)
            DST_RT:   dest_raw = f_reg(word, RS2_LSB);
            DST_LINK: dest_raw = LINK_REG;
            default:  dest_raw = f_reg(word, RD_LSB);
        endcase
    end

    always_comb begin
        dec         = '0;
        dec.ctl     = ctl;
        dec.rs1     = f_reg(word, RS1_LSB);
        dec.rs2     = f_reg(word, RS2_LSB);
        dec.imm     = f_extend(word, ctl.ex.ext_sel);
        dec.illegal = !known;
        if (ctl.wb.reg_wr && (dest_raw != '0)) begin
            dec.dest = dest_raw;
        end else begin
            dec.ctl.wb.reg_wr = 1'b0;
            dec.dest          = '0;
        end
    end

endmodule

// File: rtl/dsc_fetch_hold.sv
module dsc_fetch_hold #(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          in_valid,
    input  logic [IW-1:0] in_word,
    output logic          out_valid,
    output logic [IW-1:0] out_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (!hold) begin
            out_valid <= in_valid;
            out_word  <= in_word;
        end
    end

endmodule

// File: rtl/dsc_stage_reg.sv
module dsc_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dsc_ctl_pipe.sv
module dsc_ctl_pipe
    import dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   in_instr,
    input  logic              in_valid,
    input  logic              bubble_req,
    input  logic              stall,
    output logic [1:0]        ex_ext_sel,
    output logic              ex_alu_src,
    output logic [2:0]        ex_alu_op,
    output logic [1:0]        ex_dst_sel,
    output logic [RIDX_W-1:0] ex_rs1,
    output logic [RIDX_W-1:0] ex_rs2,
    output logic [RIDX_W-1:0] ex_dest,
    output logic [XLEN-1:0]   ex_imm,
    output logic              ex_illegal,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_branch,
    output logic              mem_br_ne,
    output logic              mem_jump,
    output logic              wb_mem_to_reg,
    output logic              wb_reg_wr,
    output logic [RIDX_W-1:0] wb_dest
);

    localparam int IDEX_W  = $bits(idex_t);
    localparam int EXMEM_W = $bits(exmem_t);
    localparam int MEMWB_W = $bits(memwb_t);

    logic            fd_valid;
    logic [XLEN-1:0] fd_word;
    idex_t           dec;
    idex_t           idex_d;
    idex_t           idex_q;
    exmem_t          exmem_d;
    exmem_t          exmem_q;
    memwb_t          memwb_d;
    memwb_t          memwb_q;

    dsc_fetch_hold #(.IW(XLEN)) i_fetch_hold (
        .clk       (clk),
        .rst       (rst),
        .hold      (stall),
        .in_valid  (in_valid),
        .in_word   (in_instr),
        .out_valid (fd_valid),
        .out_word  (fd_word)
    );

    dsc_decoder i_decoder (
        .word (fd_word),
        .dec  (dec)
    );

    assign idex_d = (fd_valid && !stall && !bubble_req) ? dec : '0;

    dsc_stage_reg #(.W(IDEX_W)) i_idex (
        .clk (clk),
        .rst (rst),
        .d   (idex_d),
        .q   (idex_q)
    );

    assign exmem_d = '{mem: idex_q.ctl.mem, wb: idex_q.ctl.wb, dest: idex_q.dest};

    dsc_stage_reg #(.W(EXMEM_W)) i_exmem (
        .clk (clk),
        .rst (rst),
        .d   (exmem_d),
        .q   (exmem_q)
    );

    assign memwb_d = '{wb: exmem_q.wb, dest: exmem_q.dest};

    dsc_stage_reg #(.W(MEMWB_W)) i_memwb (
        .clk (clk),
        .rst (rst),
        .d   (memwb_d),
        .q   (memwb_q)
    );

    assign ex_ext_sel    = idex_q.ctl.ex.ext_sel;
    assign ex_alu_src    = idex_q.ctl.ex.alu_src;
    assign ex_alu_op     = idex_q.ctl.ex.alu_op;
    assign ex_dst_sel    = idex_q.ctl.ex.dst_sel;
    assign ex_rs1        = idex_q.rs1;
    assign ex_rs2        = idex_q.rs2;
    assign ex_dest       = idex_q.dest;
    assign ex_imm        = idex_q.imm;
    assign ex_illegal    = idex_q.illegal;
    assign mem_rd        = exmem_q.mem.mem_rd;
    assign mem_wr        = exmem_q.mem.mem_wr;
    assign mem_branch    = exmem_q.mem.branch;
    assign mem_br_ne     = exmem_q.mem.br_ne;
    assign mem_jump      = exmem_q.mem.jump;
    assign wb_mem_to_reg = memwb_q.wb.mem_to_reg;
    assign wb_reg_wr     = memwb_q.wb.reg_wr;
    assign wb_dest       = memwb_q.dest;

endmodule

// File: rtl/dsc_ctl_chk.sv
module dsc_ctl_chk
    import dsc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              bubble_req,
    input logic              fd_valid,
    input logic [XLEN-1:0]   fd_word,
    input idex_t             idex_q,
    input exmem_t            exmem_q,
    input logic [1:0]        ex_ext_sel,
    input logic              ex_alu_src,
    input logic [2:0]        ex_alu_op,
    input logic [1:0]        ex_dst_sel,
    input logic [RIDX_W-1:0] ex_rs1,
    input logic [RIDX_W-1:0] ex_rs2,
    input logic [RIDX_W-1:0] ex_dest,
    input logic [XLEN-1:0]   ex_imm,
    input logic              ex_illegal,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              wb_reg_wr,
    input logic [RIDX_W-1:0] wb_dest
);

    logic ex_clear;
    assign ex_clear = (ex_ext_sel == 2'd0) && !ex_alu_src && (ex_alu_op == 3'd0)
                   && (ex_dst_sel == 2'd0) && (ex_rs1 == '0) && (ex_rs2 == '0)
                   && (ex_dest == '0) && (ex_imm == '0) && !ex_illegal;

    AST_MEM_FOLLOWS_EX: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(idex_q.ctl.mem.mem_wr)); // R3

    AST_MEM_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R3

    AST_WB_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (rst)
        wb_reg_wr |-> $past(exmem_q.wb.reg_wr)); // R4

    AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (rst)
        wb_reg_wr |-> (wb_dest != '0)); // R5

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        ex_illegal |-> (idex_q.ctl == '0) && (ex_dest == '0)); // R6

    AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        bubble_req |=> ex_clear); // R7

    AST_STALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stall |=> ex_clear); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(fd_word) && $stable(fd_valid)); // R8

    AST_EMPTY_SLOT: assert property (@(posedge clk) disable iff (rst)
        !fd_valid |=> ex_clear); // R9

endmodule

bind dsc_ctl_pipe dsc_ctl_chk i_dsc_ctl_chk (.*);

// File: tb/test_dsc_ctl_pipe.sv
module test_dsc_ctl_pipe;

    logic        clk;
    logic        rst;
    logic [31:0] in_instr;
    logic        in_valid;
    logic        bubble_req;
    logic        stall;
    logic [1:0]  ex_ext_sel;
    logic        ex_alu_src;
    logic [2:0]  ex_alu_op;
    logic [1:0]  ex_dst_sel;
    logic [4:0]  ex_rs1, ex_rs2, ex_dest;
    logic [31:0] ex_imm;
    logic        ex_illegal;
    logic        mem_rd, mem_wr, mem_branch, mem_br_ne, mem_jump;
    logic        wb_mem_to_reg, wb_reg_wr;
    logic [4:0]  wb_dest;

    dsc_ctl_pipe i_dsc_ctl_pipe (.*);

    initial clk = 1'b0;
    always #4 clk = ~clk;

    typedef struct packed {
        logic [1:0]  ext;
        logic        src;
        logic [2:0]  op;
        logic [1:0]  dsel;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [4:0]  dest;
        logic [31:0] imm;
        logic        ill;
        logic        mrd, mwr, br, brne, jmp;
        logic        m2r, rw;
    } exp_t;

    typedef struct {
        exp_t  e;
        string t;
    } item_t;

    item_t q[$];
    item_t h0, h1, h2;
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    live = 0;

    logic        m_fd_v = 1'b0;
    logic [31:0] m_fd_w = '0;
    string       m_fd_t = "R9";

    function automatic exp_t ref_dec(input logic [31:0] w);
        exp_t e;
        logic ok;
        e = '0;
        ok = 1'b1;
        case (w[31:26])
            6'h00: begin
                e.rw = 1'b1;
                case (w[5:0])
                    6'h20: e.op = 3'd0;
                    6'h22: e.op = 3'd1;
                    6'h24: e.op = 3'd2;
                    6'h25: e.op = 3'd3;
                    6'h26: e.op = 3'd4;
                    6'h2A: e.op = 3'd5;
                    default: ok = 1'b0;
                endcase
            end
            6'h23: begin e.src = 1; e.dsel = 1; e.mrd = 1; e.m2r = 1; e.rw = 1; end
            6'h2B: begin e.src = 1; e.mwr = 1; end
            6'h04: begin e.op = 3'd1; e.br = 1; end
            6'h05: begin e.op = 3'd1; e.br = 1; e.brne = 1; end
            6'h08: begin e.src = 1; e.dsel = 1; e.rw = 1; end
            6'h0A: begin e.src = 1; e.op = 3'd5; e.dsel = 1; e.rw = 1; end
            6'h0C: begin e.ext = 1; e.src = 1; e.op = 3'd2; e.dsel = 1; e.rw = 1; end
            6'h0D: begin e.ext = 1; e.src = 1; e.op = 3'd3; e.dsel = 1; e.rw = 1; end
            6'h02: begin e.ext = 2; e.jmp = 1; end
            6'h03: begin e.ext = 2; e.jmp = 1; e.dsel = 2; e.rw = 1; end
            default: ok = 1'b0;
        endcase
        if (!ok) begin
            e = '0;
            e.ill = 1'b1;
        end
        e.rs1 = w[25:21];
        e.rs2 = w[20:16];
        case (e.ext)
            2'd0: e.imm = {{16{w[15]}}, w[15:0]};
            2'd1: e.imm = {16'h0000, w[15:0]};
            default: e.imm = {6'b0, w[25:0]};
        endcase
        if (e.rw) begin
            case (e.dsel)
                2'd1: e.dest = w[20:16];
                2'd2: e.dest = 5'd31;
                default: e.dest = w[15:11];
            endcase
            if (e.dest == 5'd0) e.rw = 1'b0;
        end
        return e;
    endfunction

    function automatic logic [31:0] rr(input logic [5:0] fn, input logic [4:0] s, t, d);
        return {6'h00, s, t, d, 5'd0, fn};
    endfunction

    function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] s, t,
                                       input logic [15:0] im);
        return {op, s, t, im};
    endfunction

    task automatic chk(input string tag, input string grp, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, grp, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic v, input logic b, input logic s,
                         input string t);
        item_t it;
        @(negedge clk);
        in_instr   = w;
        in_valid   = v;
        bubble_req = b;
        stall      = s;
        it.e = '0;
        if (s) it.t = "R8";
        else if (b) it.t = "R7";
        else if (!m_fd_v) it.t = "R9";
        else begin
            it.e = ref_dec(m_fd_w);
            it.t = m_fd_t;
        end
        q.push_back(it);
        if (!s) begin
            m_fd_v = v;
            m_fd_w = w;
            m_fd_t = t;
        end
    endtask

    initial begin
        h0 = '{e: '0, t: "R9"};
        h1 = h0;
        h2 = h0;
        forever begin
            @(posedge clk);
            #2;
            if (live) begin
                h2 = h1;
                h1 = h0;
                if (q.size() > 0) h0 = q.pop_front();
                else h0 = '{e: '0, t: "R9"};
                chk(h0.t, "ex",
                    64'({ex_ext_sel, ex_alu_src, ex_alu_op, ex_dst_sel, ex_rs1, ex_rs2, ex_dest, ex_illegal}),
                    64'({h0.e.ext, h0.e.src, h0.e.op, h0.e.dsel, h0.e.rs1, h0.e.rs2, h0.e.dest, h0.e.ill}));
                chk(h0.t, "ex_imm", 64'(ex_imm), 64'(h0.e.imm));
                chk(h1.t, "mem", 64'({mem_rd, mem_wr, mem_branch, mem_br_ne, mem_jump}),
                    64'({h1.e.mrd, h1.e.mwr, h1.e.br, h1.e.brne, h1.e.jmp}));
                chk(h2.t, "wb", 64'({wb_mem_to_reg, wb_reg_wr, wb_dest}),
                    64'({h2.e.m2r, h2.e.rw, h2.e.dest}));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_instr = rr(6'h20, 5'd1, 5'd2, 5'd3);
        in_valid = 1'b1;
        bubble_req = 1'b0;
        stall = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        // R10: reset clears every output
        chk("R10", "reset",
            64'({ex_ext_sel, ex_alu_src, ex_alu_op, ex_dst_sel, ex_rs1, ex_rs2, ex_dest, ex_illegal,
                 mem_rd, mem_wr, mem_branch, mem_br_ne, mem_jump, wb_mem_to_reg, wb_reg_wr, wb_dest}),
            64'd0);
        chk("R10", "reset_imm", 64'(ex_imm), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        live = 1'b1;

        // R2 R4: register-register operations
        issue(rr(6'h20, 5'd1, 5'd2, 5'd3), 1, 0, 0, "R2");
        issue(rr(6'h22, 5'd4, 5'd5, 5'd6), 1, 0, 0, "R2");
        issue(rr(6'h24, 5'd7, 5'd8, 5'd9), 1, 0, 0, "R2");
        issue(rr(6'h25, 5'd10, 5'd11, 5'd12), 1, 0, 0, "R2");
        issue(rr(6'h26, 5'd13, 5'd14, 5'd15), 1, 0, 0, "R2");
        issue(rr(6'h2A, 5'd16, 5'd17, 5'd18), 1, 0, 0, "R2");
        // R3 R4: load then register-register back to back
        issue(ri(6'h23, 5'd1, 5'd5, 16'hFFFC), 1, 0, 0, "R4");
        issue(rr(6'h20, 5'd5, 5'd5, 5'd7), 1, 0, 0, "R4");
        issue(ri(6'h2B, 5'd2, 5'd6, 16'h0010), 1, 0, 0, "R3");
        issue(ri(6'h04, 5'd1, 5'd3, 16'h8000), 1, 0, 0, "R3");
        issue(ri(6'h05, 5'd1, 5'd3, 16'h0007), 1, 0, 0, "R3");
        // R1: immediate extension forms
        issue(ri(6'h08, 5'd3, 5'd4, 16'hFF80), 1, 0, 0, "R1");
        issue(ri(6'h0C, 5'd3, 5'd4, 16'h8001), 1, 0, 0, "R1");
        issue(ri(6'h0D, 5'd9, 5'd20, 16'hF00F), 1, 0, 0, "R1");
        issue(ri(6'h0A, 5'd9, 5'd21, 16'h8000), 1, 0, 0, "R2");
        issue({6'h02, 26'h3ABCDEF}, 1, 0, 0, "R1");
        issue({6'h03, 26'h2000001}, 1, 0, 0, "R5");
        // R5: register 0 destination
        issue(rr(6'h20, 5'd1, 5'd2, 5'd0), 1, 0, 0, "R5");
        issue(ri(6'h08, 5'd1, 5'd0, 16'h0001), 1, 0, 0, "R5");
        issue(ri(6'h23, 5'd1, 5'd0, 16'h0004), 1, 0, 0, "R5");
        // R6: unknown opcode and unknown function
        issue(ri(6'h3F, 5'd7, 5'd8, 16'h9000), 1, 0, 0, "R6");
        issue(rr(6'h01, 5'd7, 5'd8, 5'd9), 1, 0, 0, "R6");
        // R7: bubble squashes the decoding store
        issue(ri(6'h2B, 5'd1, 5'd2, 16'h0004), 1, 0, 0, "R7");
        issue(rr(6'h22, 5'd3, 5'd4, 5'd5), 1, 1, 0, "R7");
        issue(ri(6'h08, 5'd0, 5'd6, 16'h0002), 1, 0, 0, "R7");
        // R8: two stall cycles, words offered during the stall are dropped
        issue(ri(6'h23, 5'd2, 5'd9, 16'h0020), 1, 0, 0, "R8");
        issue(rr(6'h26, 5'd1, 5'd1, 5'd1), 1, 0, 1, "R8");
        issue(ri(6'h2B, 5'd3, 5'd3, 16'h0003), 1, 0, 1, "R8");
        issue(rr(6'h24, 5'd9, 5'd2, 5'd10), 1, 0, 0, "R8");
        issue(rr(6'h25, 5'd10, 5'd9, 5'd11), 1, 0, 0, "R8");
        // R9: invalid slot between valid ones
        issue(rr(6'h20, 5'd1, 5'd2, 5'd3), 0, 0, 0, "R9");
        issue(ri(6'h0D, 5'd4, 5'd5, 16'h1234), 1, 0, 0, "R9");
        for (int i = 0; i < 5; i++) issue(32'h0, 0, 0, 0, "R9");
        @(posedge clk);
        #3;
        live = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule